// File: doc/BRIEF.md
# Undertone-Locking Oscillator Sync Controller

This block contains two digital phase-accumulator oscillators and the sync logic that links them. The primary oscillator runs freely. The secondary can be restarted, but only under a two-step rule. A primary wrap restarts the secondary only if the secondary has already finished at least one full cycle of its own. Primary wraps that arrive earlier are skipped.

When the secondary is tuned below the primary, this pulse skipping makes it lock to an integer fraction of the primary rate, which is an undertone. When the secondary is tuned faster than the primary, the same logic behaves like ordinary hard sync.

A mode input selects one-shot behaviour instead. In that mode the secondary completes one cycle, then parks at phase zero until the next primary wrap releases it. Both phase words, both wrap strobes and the two sync state bits are outputs.

Top module: `undertone_sync_osc`

## Requirements
- R1: On every clock with `tick` high, `prim_phase` advances by `prim_inc` modulo 2^W. With `tick` low, it holds its value.
- R2: `prim_eoc` is high for exactly the one clock that follows a ticked primary addition that overflowed. At all other times it is low.
- R3: `cyc_done` goes high in the clock after a secondary wrap. It stays high until the secondary is restarted.
- R4: On each primary wrap, `sync_pend` loads the value that `cyc_done` held before that clock edge. A primary wrap while `cyc_done` is low is skipped, and `sync_pend` stays low.
- R5: In the clock after `sync_pend` is seen high, `sec_phase` is 0 and both `cyc_done` and `sync_pend` are 0. This restart overrides any wrap in that clock.
- R6: If the primary and the secondary wrap on the same tick, `cyc_done` becomes 1. `sync_pend` takes the old value of `cyc_done`, so the restart waits for the following primary wrap.
- R7: With `mode_oneshot` = 1, the secondary wrap itself loads phase 0. While `cyc_done` stays 1, `sec_phase` stays 0 and `sec_eoc` stays low. With `mode_oneshot` = 0, the secondary keeps running after a wrap.
- R8: `sec_eoc` is high for one clock after a ticked secondary addition that overflowed. A secondary that is restarting or held never produces it.
- R9: While `rst` is high, both phases, both strobes, `cyc_done` and `sync_pend` are all zero in the clock that follows.
- R10: With `tick` held high, `prim_inc` = 0x4000 and `sec_inc` = 0x1800 (W = 16), restarts settle to one every 16 clocks. That is one restart per four primary cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable; both accumulators advance only when high |
| mode_oneshot | input | 1 | 0 = pulse-skipping sync, 1 = one-cycle-then-hold |
| prim_inc | input | W | Primary tuning word |
| sec_inc | input | W | Secondary tuning word |
| prim_phase | output | W | Primary phase accumulator |
| sec_phase | output | W | Secondary phase accumulator |
| prim_eoc | output | 1 | Primary end-of-cycle strobe |
| sec_eoc | output | 1 | Secondary end-of-cycle strobe |
| cyc_done | output | 1 | Secondary has completed a cycle since its last restart |
| sync_pend | output | 1 | Restart of the secondary is due this clock |

## Verification
A primary wrap and a secondary wrap can land on the same tick. When they do, setting `cyc_done` and sampling it into `sync_pend` must happen in a fixed order. The tuning pair 0x4000/0x1800 forces that collision 12 ticks after every restart. The bench judges the outcome two ways: `sync_pend` must stay low at the collision, and the steady restart spacing must be 16 clocks rather than 12. A restart clock that coincides with a primary wrap is also covered, and the reference model expects the restart to win.

// File: rtl/undertone_pkg.sv
package undertone_pkg;

    typedef enum logic {
        SYNC_SKIP    = 1'b0,
        SYNC_ONESHOT = 1'b1
    } sync_mode_e;

    typedef struct packed {
        logic done;   // secondary finished a cycle
        logic pend;   // restart due
    } sync_state_t;

    function automatic logic hold_active(sync_mode_e m, sync_state_t s);
        return (m == SYNC_ONESHOT) && s.done;
    endfunction

endpackage

// File: rtl/undertone_phase_acc.sv
module undertone_phase_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] inc,
    input  logic         clr,
    input  logic         zero_on_wrap,
    output logic [W-1:0] phase,
    output logic         wrap,
    output logic         eoc
);
    logic [W:0] sum;

    assign sum  = {1'b0, phase} + {1'b0, inc};
    assign wrap = tick && !clr && sum[W];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            eoc   <= 1'b0;
        end else begin
            eoc <= wrap;
            if (clr)
                phase <= '0;
            else if (tick)
                phase <= (wrap && zero_on_wrap) ? '0 : sum[W-1:0];
        end
    end
endmodule

// File: rtl/undertone_sync_ctrl.sv
module undertone_sync_ctrl
    import undertone_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sync_mode_e  mode,
    input  logic        prim_wrap,
    input  logic        sec_wrap,
    output sync_state_t st,
    output logic        restart,
    output logic        hold
);
    assign restart = st.pend;
    assign hold    = hold_active(mode, st);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st <= '0;
        end else begin
            if (sec_wrap)
                st.done <= 1'b1;
            if (prim_wrap)
                st.pend <= st.done;
        end
    end
endmodule

// File: rtl/undertone_sync_osc.sv
module undertone_sync_osc
    import undertone_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         mode_oneshot,
    input  logic [W-1:0] prim_inc,
    input  logic [W-1:0] sec_inc,
    output logic [W-1:0] prim_phase,
    output logic [W-1:0] sec_phase,
    output logic         prim_eoc,
    output logic         sec_eoc,
    output logic         cyc_done,
    output logic         sync_pend
);
    sync_mode_e  mode;
    sync_state_t st;
    logic        prim_wrap, sec_wrap, restart, hold;

    assign mode = sync_mode_e'(mode_oneshot);

    undertone_phase_acc #(.W(W)) u_prim (
        .clk(clk), .rst(rst), .tick(tick), .inc(prim_inc),
        .clr(1'b0), .zero_on_wrap(1'b0),
        .phase(prim_phase), .wrap(prim_wrap), .eoc(prim_eoc)
    );

    undertone_phase_acc #(.W(W)) u_sec (
        .clk(clk), .rst(rst), .tick(tick), .inc(sec_inc),
        .clr(restart || hold), .zero_on_wrap(mode == SYNC_ONESHOT),
        .phase(sec_phase), .wrap(sec_wrap), .eoc(sec_eoc)
    );

    undertone_sync_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mode(mode),
        .prim_wrap(prim_wrap), .sec_wrap(sec_wrap),
        .st(st), .restart(restart), .hold(hold)
    );

    assign cyc_done  = st.done;
    assign sync_pend = st.pend;
endmodule

// File: rtl/undertone_sync_chk.sv
module undertone_sync_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         mode_oneshot,
    input logic [W-1:0] prim_phase,
    input logic [W-1:0] sec_phase,
    input logic         prim_eoc,
    input logic         sec_eoc,
    input logic         cyc_done,
    input logic         sync_pend
);
    // R1
    prim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(prim_phase));

    // R2
    prim_eoc_tick_chk: assert property (@(posedge clk) disable iff (rst)
        prim_eoc |-> $past(tick));

    // R3
    sec_eoc_done_chk: assert property (@(posedge clk) disable iff (rst)
        sec_eoc |-> cyc_done);

    // R4
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_done && !sync_pend) |=> !sync_pend);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        sync_pend |=> (sec_phase == '0) && !cyc_done && !sync_pend && !sec_eoc);

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_oneshot && cyc_done && !sync_pend) |=> (sec_phase == '0) && !sec_eoc);
endmodule

bind undertone_sync_osc undertone_sync_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode_oneshot(mode_oneshot),
    .prim_phase(prim_phase), .sec_phase(sec_phase),
    .prim_eoc(prim_eoc), .sec_eoc(sec_eoc),
    .cyc_done(cyc_done), .sync_pend(sync_pend)
);

// File: tb/test_undertone_sync_osc.sv
module test_undertone_sync_osc;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] pp, sp;
        logic pe, se, dn, pd;
        string tag_pd;
        bit    rst_chk;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         mode_oneshot = 1'b0;
    logic [W-1:0] prim_inc = '0;
    logic [W-1:0] sec_inc = '0;
    logic [W-1:0] prim_phase, sec_phase;
    logic         prim_eoc, sec_eoc, cyc_done, sync_pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    exp_t q[$];

    // reference state
    logic [W-1:0] m_pa = '0, m_sa = '0;
    logic m_pe = 0, m_se = 0, m_dn = 0, m_pd = 0;

    always #2 clk = ~clk;

    undertone_sync_osc #(.W(W)) i_undertone_sync_osc (
        .clk(clk), .rst(rst), .tick(tick), .mode_oneshot(mode_oneshot),
        .prim_inc(prim_inc), .sec_inc(sec_inc),
        .prim_phase(prim_phase), .sec_phase(sec_phase),
        .prim_eoc(prim_eoc), .sec_eoc(sec_eoc),
        .cyc_done(cyc_done), .sync_pend(sync_pend)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock of stimulus; model follows the requirements
    task automatic step(logic t, logic md, logic [W-1:0] pi, logic [W-1:0] si, logic r);
        exp_t e;
        logic [W:0] ps, ss;
        logic pw, sw, restart, hold;
        tick = t; mode_oneshot = md; prim_inc = pi; sec_inc = si; rst = r;
        e.tag_pd = "R4";
        e.rst_chk = r;
        if (r) begin
            m_pa = '0; m_sa = '0; m_pe = 0; m_se = 0; m_dn = 0; m_pd = 0;
        end else begin
            restart = m_pd;
            hold = md && m_dn;
            ps = {1'b0, m_pa} + {1'b0, pi};
            pw = t && ps[W];
            if (t) m_pa = ps[W-1:0];
            sw = 1'b0;
            if (restart || hold) begin
                m_sa = '0;
            end else begin
                ss = {1'b0, m_sa} + {1'b0, si};
                sw = t && ss[W];
                if (t) m_sa = (md && sw) ? '0 : ss[W-1:0];
            end
            if (restart) begin
                m_dn = 0; m_pd = 0;
            end else begin
                if (pw && sw && !m_dn) e.tag_pd = "R6";
                if (pw) m_pd = m_dn;
                if (sw) m_dn = 1;
            end
            m_pe = pw; m_se = sw;
        end
        e.pp = m_pa; e.sp = m_sa; e.pe = m_pe; e.se = m_se; e.dn = m_dn; e.pd = m_pd;
        @(posedge clk);
        q.push_back(e);
        #1;
    endtask

    // monitor: compares half a cycle after each edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.rst_chk) begin
                chk("R9 reset prim_phase", prim_phase, e.pp);
                chk("R9 reset sec_phase", sec_phase, e.sp);
                chk("R9 reset flags", {12'd0, prim_eoc, sec_eoc, cyc_done, sync_pend}, 16'd0);
            end else begin
                chk("R1 prim_phase", prim_phase, e.pp);
                chk("R2 prim_eoc", {15'd0, prim_eoc}, {15'd0, e.pe});
                chk("R8 sec_eoc", {15'd0, sec_eoc}, {15'd0, e.se});
                chk("R3 cyc_done", {15'd0, cyc_done}, {15'd0, e.dn});
                chk({e.tag_pd, " sync_pend"}, {15'd0, sync_pend}, {15'd0, e.pd});
                chk("R5 R7 sec_phase", sec_phase, e.sp);
            end
        end
    end

    initial begin
        int last_req, prev_req;
        last_req = -1; prev_req = -1;
        // R9: reset state
        repeat (3) step(1, 0, 16'h1234, 16'h0777, 1);

        // R10 / R6: undertone lock with coincident wraps
        for (int i = 0; i < 120; i++) begin
            step(1, 0, 16'h4000, 16'h1800, 0);
            if (sync_pend) begin
                prev_req = last_req;
                last_req = i;
            end
        end
        n_cmp++;
        if (last_req - prev_req != 16) begin
            n_bad++;
            $display("FAIL R10: restart spacing actual %0d expected 16", last_req - prev_req);
        end

        // R1: gated ticks, secondary faster (plain hard sync)
        for (int i = 0; i < 150; i++)
            step((i % 3) != 1, 0, 16'h1100, 16'h5300, 0);

        // R7: one-shot mode
        for (int i = 0; i < 150; i++)
            step(1, 1, 16'h0C00, 16'h2900, 0);

        // R7 with gated ticks, then mode switch back
        for (int i = 0; i < 100; i++)
            step((i % 4) != 0, (i < 50), 16'h0900, 16'h3100, 0);

        // R2: very high primary rate, wraps on consecutive ticks
        for (int i = 0; i < 60; i++)
            step(1, 0, 16'hF000, 16'h0400, 0);

        // R9: reset mid-run
        step(1, 0, 16'h4000, 16'h1800, 1);
        for (int i = 0; i < 40; i++)
            step(1, 0, 16'h4000, 16'h1800, 0);

        step(0, 0, '0, '0, 0);
        step(0, 0, '0, '0, 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule